// File: doc/BRIEF.md
# DDR Read Burst Interruption Scheduler

This block schedules read data on the memory side of a double-data-rate synchronous DRAM. It takes READ and PRECHARGE commands, each carrying a bank and a column address. After the programmed CAS latency it drives two data beats per clock: one for the rising half and one for the falling half. Each half also gets its own strobe-enable bit.

A later command can cut a burst short while it is still being issued:
- A READ to a different bank starts its own burst at exactly the half-cycle where that burst's first beat is due. The older burst stops at that point.
- A PRECHARGE to the bank being read removes every beat that would appear one CAS latency or more after the PRECHARGE.

The CAS latency can be 2 or 2.5 clocks, so output timing is resolved in half-clock slots. Read data is a fixed pattern built from the bank, the column and the beat offset, so the block needs no storage array.

Top module: `ddr_rd_sched`

## Requirements
- R1: While rst_ni is low, dqs_en_o, dq_rise_o, dq_fall_o and cmd_err_o are all zero.
- R2: With cl_half_i=0 (CAS latency 2), a READ sampled in cycle t puts beat 2k on the rising half and beat 2k+1 on the falling half of cycle t+2+k, for every k below BL/2.
- R3: With cl_half_i=1 (CAS latency 2.5), a READ in cycle t puts beat 2k on the falling half of cycle t+2+k and beat 2k+1 on the rising half of cycle t+3+k.
- R4: cfg_bl_i selects the burst length: 0 gives 2 beats, 1 gives 4 beats, and 2 or 3 give 8 beats. An uninterrupted burst ends after BL/2 clocks.
- R5: Beat b of a READ to bank B at column C carries the 16-bit word {1'b1, B[1:0], C[9:0], b[2:0]}.
- R6: The bursting bank is the bank of the last accepted READ, during cycles t+1 through t+BL/2-1. A READ to another bank in any cycle truncates the old burst at the new burst's first half-slot. READs one clock apart each give exactly two beats, even when their column addresses are unrelated.
- R7: A PRECHARGE in cycle p to the bursting bank suppresses every beat whose half-slot falls one CAS latency or more after p. With CAS latency 2, READ-to-PRECHARGE spacings of 1, 2 and 3 clocks leave 2, 4 and 6 beats.
- R8: A READ to the bursting bank raises cmd_err_o for the following cycle and leaves the output stream unchanged.
- R9: A PRECHARGE to any bank that is not bursting raises cmd_err_o for the following cycle and leaves the output stream unchanged.
- R10: In any half with no scheduled beat, the matching strobe-enable bit (bit 0 for the rising half, bit 1 for the falling half) is low and that half's data bus is zero. This includes the gap after a truncated burst.
- R11: With CAS latency 2, both strobe-enable bits are always equal.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| cmd_valid_i | input | 1 | A command is present this cycle |
| cmd_pre_i | input | 1 | 1 means PRECHARGE, 0 means READ |
| cmd_bank_i | input | 2 | Bank address |
| cmd_col_i | input | 10 | Column address (used by READ) |
| cfg_bl_i | input | 2 | Burst length select (static) |
| cl_half_i | input | 1 | 0 means CAS latency 2, 1 means CAS latency 2.5 (static) |
| dqs_en_o | output | 2 | Strobe enable: bit 0 for the rising half, bit 1 for the falling half |
| dq_rise_o | output | 16 | Beat for the rising half |
| dq_fall_o | output | 16 | Beat for the falling half |
| cmd_err_o | output | 1 | The previous command was illegal and was ignored |

## Verification
Some properties are checked by the assertions on every cycle:
- a matched PRECHARGE empties the next launch slot;
- an accepted READ launches beat zero on the next cycle;
- the remaining-pair count stays within the selected burst length;
- with CAS latency 2, both halves are always paired;
- idle halves carry zero data;
- with CAS latency 2.5, every rising-half beat follows a falling-half beat.

Other behaviour can only be shown by the bench's scenarios, which compare every half-slot against a timeline built from the requirements. These cover the exact beat positions and data words, truncation by an interrupting READ with unrelated columns, and the 2/4/6-beat truncation by PRECHARGE at both latencies. They also cover the error cases, where an illegal command must leave the stream untouched.

// File: rtl/ddr_rd_pkg.sv
package ddr_rd_pkg;
  localparam int BANK_W = 2;
  localparam int COL_W  = 10;
  localparam int BEAT_W = 3;                          // log2 of the largest burst
  localparam int DW     = 1 + BANK_W + COL_W + BEAT_W;
  localparam int PAIR_W = BEAT_W;                     // pair counter width

  typedef struct packed {
    logic          vld;
    logic [DW-1:0] d0;
    logic [DW-1:0] d1;
  } pair_t;

  function automatic logic [DW-1:0] beat_word(logic [BANK_W-1:0] bank,
                                              logic [COL_W-1:0]  col,
                                              logic [BEAT_W-1:0] beat);
    return {1'b1, bank, col, beat};
  endfunction

  // number of two-beat pairs per burst
  function automatic logic [PAIR_W-1:0] bl_pairs(logic [1:0] sel);
    case (sel)
      2'd0:    return PAIR_W'(1);
      2'd1:    return PAIR_W'(2);
      default: return PAIR_W'(4);
    endcase
  endfunction
endpackage

// File: rtl/ddr_rd_burst_ctl.sv
module ddr_rd_burst_ctl
  import ddr_rd_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cmd_valid_i,
  input  logic              cmd_pre_i,
  input  logic [BANK_W-1:0] cmd_bank_i,
  input  logic [COL_W-1:0]  cmd_col_i,
  input  logic [1:0]        cfg_bl_i,
  output pair_t             launch_o,
  output logic              err_o
);
  logic              act_q;
  logic [BANK_W-1:0] bank_q;
  logic [COL_W-1:0]  col_q;
  logic [PAIR_W-1:0] left_q, idx_q;
  logic [PAIR_W-1:0] pairs_total;
  logic rd, pr, same_bank, rd_hit, rd_go, pr_hit, pr_err;

  assign pairs_total = bl_pairs(cfg_bl_i);
  assign rd        = cmd_valid_i & ~cmd_pre_i;
  assign pr        = cmd_valid_i &  cmd_pre_i;
  assign same_bank = act_q & (cmd_bank_i == bank_q);
  assign rd_hit    = rd & same_bank;
  assign rd_go     = rd & ~same_bank;
  assign pr_hit    = pr & same_bank;
  assign pr_err    = pr & ~same_bank;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      act_q    <= 1'b0;
      bank_q   <= '0;
      col_q    <= '0;
      left_q   <= '0;
      idx_q    <= '0;
      launch_o <= '0;
      err_o    <= 1'b0;
    end else begin
      err_o <= rd_hit | pr_err;
      if (rd_go) begin
        bank_q       <= cmd_bank_i;
        col_q        <= cmd_col_i;
        idx_q        <= PAIR_W'(1);
        left_q       <= pairs_total - PAIR_W'(1);
        act_q        <= (pairs_total > PAIR_W'(1));
        launch_o.vld <= 1'b1;
        launch_o.d0  <= beat_word(cmd_bank_i, cmd_col_i, BEAT_W'(0));
        launch_o.d1  <= beat_word(cmd_bank_i, cmd_col_i, BEAT_W'(1));
      end else if (pr_hit) begin
        act_q    <= 1'b0;
        left_q   <= '0;
        launch_o <= '0;
      end else if (act_q) begin
        idx_q        <= idx_q + PAIR_W'(1);
        left_q       <= left_q - PAIR_W'(1);
        act_q        <= (left_q > PAIR_W'(1));
        launch_o.vld <= 1'b1;
        launch_o.d0  <= beat_word(bank_q, col_q, BEAT_W'({idx_q, 1'b0}));
        launch_o.d1  <= beat_word(bank_q, col_q, BEAT_W'({idx_q, 1'b1}));
      end else begin
        launch_o <= '0;
      end
    end
  end

  AST_PRE_STOPS_LAUNCH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pr_hit |=> !launch_o.vld); // R7
  AST_READ_STARTS_AT_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_go |=> launch_o.vld && launch_o.d0[BEAT_W-1:0] == '0); // R6
  AST_ERR_KEEPS_BANK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_hit |=> $stable(bank_q) && err_o); // R8
  AST_LEFT_IN_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    left_q < pairs_total); // R4
endmodule

// File: rtl/ddr_rd_lat_pipe.sv
module ddr_rd_lat_pipe
  import ddr_rd_pkg::*;
(
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          cl_half_i,
  input  pair_t         launch_i,
  output logic [1:0]    dqs_en_o,
  output logic [DW-1:0] dq_rise_o,
  output logic [DW-1:0] dq_fall_o
);
  pair_t s1_q, s2_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_q <= '0;
      s2_q <= '0;
    end else begin
      s1_q <= launch_i;
      s2_q <= s1_q;
    end
  end

  // latency 2.5: the first beat lands on the falling half, the second half-cycle later
  always_comb begin
    if (cl_half_i) begin
      dqs_en_o  = {s1_q.vld, s2_q.vld};
      dq_rise_o = s2_q.d1;
      dq_fall_o = s1_q.d0;
    end else begin
      dqs_en_o  = {s1_q.vld, s1_q.vld};
      dq_rise_o = s1_q.d0;
      dq_fall_o = s1_q.d1;
    end
  end

  AST_CL2_HALVES_PAIRED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cl_half_i |-> dqs_en_o[0] == dqs_en_o[1]); // R11
  AST_IDLE_RISE_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !dqs_en_o[0] |-> dq_rise_o == '0); // R10
  AST_IDLE_FALL_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !dqs_en_o[1] |-> dq_fall_o == '0); // R10
  AST_HALF_SHIFT_ORDER: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cl_half_i && dqs_en_o[0]) |-> $past(dqs_en_o[1])); // R3
endmodule

// File: rtl/ddr_rd_sched.sv
module ddr_rd_sched
  import ddr_rd_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cmd_valid_i,
  input  logic              cmd_pre_i,
  input  logic [BANK_W-1:0] cmd_bank_i,
  input  logic [COL_W-1:0]  cmd_col_i,
  input  logic [1:0]        cfg_bl_i,
  input  logic              cl_half_i,
  output logic [1:0]        dqs_en_o,
  output logic [DW-1:0]     dq_rise_o,
  output logic [DW-1:0]     dq_fall_o,
  output logic              cmd_err_o
);
  pair_t launch;

  ddr_rd_burst_ctl u_ctl (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .cmd_valid_i (cmd_valid_i),
    .cmd_pre_i   (cmd_pre_i),
    .cmd_bank_i  (cmd_bank_i),
    .cmd_col_i   (cmd_col_i),
    .cfg_bl_i    (cfg_bl_i),
    .launch_o    (launch),
    .err_o       (cmd_err_o)
  );

  ddr_rd_lat_pipe u_pipe (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .cl_half_i (cl_half_i),
    .launch_i  (launch),
    .dqs_en_o  (dqs_en_o),
    .dq_rise_o (dq_rise_o),
    .dq_fall_o (dq_fall_o)
  );

  AST_RESET_QUIET: assert property (@(posedge clk_i)
    !rst_ni |-> dqs_en_o == 2'b00 && !cmd_err_o); // R1
endmodule

// File: tb/ddr_rd_sched_tb_top.sv
module ddr_rd_sched_tb_top;
  localparam int NSLOT = 4096;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cmd_valid = 1'b0, cmd_pre = 1'b0;
  logic [1:0]  cmd_bank = '0;
  logic [9:0]  cmd_col = '0;
  logic [1:0]  cfg_bl = 2'd2;
  logic        cl_half = 1'b0;
  logic [1:0]  dqs_en;
  logic [15:0] dq_rise, dq_fall;
  logic        cmd_err;

  int checks = 0, fails = 0, cyc = 0;
  bit          exp_v   [NSLOT];
  logic [15:0] exp_d   [NSLOT];
  int          exp_r   [NSLOT];
  bit          exp_err [NSLOT];
  int          err_r   [NSLOT];
  bit m_act = 0; logic [1:0] m_bank = '0; int m_end = 0;

  always #2.5 clk = ~clk; // 200 MHz

  ddr_rd_sched dut_i (
    .clk_i(clk), .rst_ni(rst_n), .cmd_valid_i(cmd_valid), .cmd_pre_i(cmd_pre),
    .cmd_bank_i(cmd_bank), .cmd_col_i(cmd_col), .cfg_bl_i(cfg_bl), .cl_half_i(cl_half),
    .dqs_en_o(dqs_en), .dq_rise_o(dq_rise), .dq_fall_o(dq_fall), .cmd_err_o(cmd_err)
  );

  always @(posedge clk) cyc <= cyc + 1;

  function automatic int bl_beats(logic [1:0] s);
    return (s == 2'd0) ? 2 : (s == 2'd1) ? 4 : 8;
  endfunction

  function automatic logic [15:0] word(logic [1:0] b, logic [9:0] c, int beat); // R5
    return {1'b1, b, c, 3'(beat)};
  endfunction

  task automatic clear_from(int s);
    for (int i = s; i < s + 24 && i < NSLOT; i++) exp_v[i] = 0;
  endtask

  // driver: drives one command for the current cycle and updates the scoreboard
  task automatic issue(bit pre, logic [1:0] b, logic [9:0] c, int tag);
    int t, s, n;
    bit active;
    @(negedge clk);
    cmd_valid = 1'b1; cmd_pre = pre; cmd_bank = b; cmd_col = c;
    t = cyc;
    active = m_act && (t <= m_end);
    s = 2 * (t + 2) + int'(cl_half);
    if (active && b == m_bank) begin
      if (!pre) begin exp_err[t+1] = 1; err_r[t+1] = 8; end // R8
      else begin clear_from(s); m_act = 0; end                // R7
    end else if (pre) begin
      exp_err[t+1] = 1; err_r[t+1] = 9;                        // R9
    end else begin
      n = bl_beats(cfg_bl);
      clear_from(s);                                           // R6
      for (int i = 0; i < n; i++) begin
        exp_v[s+i] = 1; exp_d[s+i] = word(b, c, i); exp_r[s+i] = tag;
      end
      m_act = 1; m_bank = b; m_end = t + n / 2 - 1;
    end
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      cmd_valid = 1'b0; cmd_pre = 1'b0;
    end
  endtask

  task automatic chk(bit ok, string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s cycle %0d: actual %h expected %h", req, cyc, act, exp);
    end
  endtask

  task automatic check_half(int slot, bit v, logic [15:0] d);
    string rq;
    if (exp_v[slot]) begin
      rq = $sformatf("R%0d", exp_r[slot]);
      chk(v === 1'b1, rq, 32'(v), 32'd1);
      chk(d === exp_d[slot], "R5", 32'(d), 32'(exp_d[slot]));
    end else begin
      chk(v === 1'b0, "R10", 32'(v), 32'd0);
      chk(d === 16'h0, "R10", 32'(d), 32'd0);
    end
  endtask

  // monitor: pops each cycle's expected half-slots and compares
  initial begin
    forever begin
      @(negedge clk);
      if (rst_n) begin
        check_half(2 * cyc, dqs_en[0], dq_rise);
        check_half(2 * cyc + 1, dqs_en[1], dq_fall);
        chk(cmd_err === exp_err[cyc], $sformatf("R%0d", exp_err[cyc] ? err_r[cyc] : 8),
            32'(cmd_err), 32'(exp_err[cyc]));
        if (!cl_half) chk(dqs_en[0] === dqs_en[1], "R11", 32'(dqs_en), 32'(dqs_en[0] ? 3 : 0));
      end
    end
  end

  task automatic report();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired at cycle %0d: actual hung expected done", cyc);
    report();
  end

  initial begin
    foreach (exp_v[i]) begin exp_v[i] = 0; exp_d[i] = '0; exp_r[i] = 0; exp_err[i] = 0; err_r[i] = 0; end
    #7;
    // R1: reset state
    chk(dqs_en === 2'b00, "R1", 32'(dqs_en), 0);
    chk(dq_rise === 16'h0 && dq_fall === 16'h0, "R1", {dq_rise, dq_fall}, 0);
    chk(cmd_err === 1'b0, "R1", 32'(cmd_err), 0);
    @(negedge clk); rst_n = 1'b1;
    idle(3);

    // R2 R4: latency 2, all burst lengths
    cfg_bl = 2'd2; issue(0, 2'd0, 10'h015, 2); idle(8);
    cfg_bl = 2'd1; issue(0, 2'd1, 10'h2a3, 4); idle(6);
    cfg_bl = 2'd0; issue(0, 2'd3, 10'h3ff, 4); idle(6);
    cfg_bl = 2'd3; issue(0, 2'd2, 10'h100, 4); idle(8);

    // R6: READs one clock apart, random columns, then one running full length
    issue(0, 2'd0, 10'h001, 6); issue(0, 2'd1, 10'h37c, 6);
    issue(0, 2'd2, 10'h0f0, 6); issue(0, 2'd3, 10'h155, 6); idle(8);
    issue(0, 2'd1, 10'h020, 6); idle(1); issue(0, 2'd3, 10'h041, 6); idle(8);

    // R7: precharge truncation at spacings 1, 2, 3
    issue(0, 2'd2, 10'h0aa, 7); issue(1, 2'd2, 10'h000, 7); idle(8);
    issue(0, 2'd2, 10'h0ab, 7); idle(1); issue(1, 2'd2, 10'h000, 7); idle(8);
    issue(0, 2'd2, 10'h0ac, 7); idle(2); issue(1, 2'd2, 10'h000, 7); idle(8);

    // R8 R9: illegal commands leave the stream unchanged
    issue(0, 2'd1, 10'h0cc, 8); issue(0, 2'd1, 10'h3cc, 8); issue(1, 2'd0, 10'h000, 9); idle(8);
    issue(1, 2'd3, 10'h000, 9); idle(4);
    cfg_bl = 2'd0; issue(0, 2'd0, 10'h010, 9); issue(1, 2'd0, 10'h000, 9); idle(6);

    // R3: latency 2.5, full burst, interrupts, precharge
    cfg_bl = 2'd2; cl_half = 1'b1; idle(4);
    issue(0, 2'd3, 10'h123, 3); idle(8);
    issue(0, 2'd0, 10'h200, 3); issue(0, 2'd1, 10'h011, 3); idle(1);
    issue(0, 2'd2, 10'h3a5, 3); idle(8);
    issue(0, 2'd1, 10'h066, 7); issue(1, 2'd1, 10'h000, 7); idle(8);
    issue(0, 2'd1, 10'h067, 7); idle(2); issue(1, 2'd1, 10'h000, 7); idle(8);
    cfg_bl = 2'd1; issue(0, 2'd0, 10'h0d0, 4); idle(8);
    cl_half = 1'b0; idle(4);
    report();
  end
endmodule